// File: doc/BRIEF.md
# Half-Bridge Shoot-Through Interlock with Deadtime

This block sits between a PWM source and one phase of a half-bridge gate driver. It accepts a high-side switch request and a low-side switch request as logic levels. It turns them into two gate enables that can never be on together. Each request first passes through a pulse filter, so a level that does not hold for a minimum number of clock cycles never reaches the gates. The low-side request can be read active-high or active-low, as chosen by a mode input. When both effective requests are asserted at once, both gates are held off.

Whenever a gate turns off, a deadtime counter starts. No gate may turn on until that count has expired. The deadtime length is either a built-in default or a value supplied on a configuration input. A new value is taken only while no count is running. The block is fully synchronous, with one clock and a synchronous active-high reset.

Top module: `hb_interlock`

## Requirements
- R1: While `rst` is high, and during the first clock cycle after it falls, `hs_gate` and `ls_gate` are both 0.
- R2: A change on `hs_req` or `ls_req` that lasts fewer than `FILT_CYC` consecutive clock cycles (default 7) has no effect on either gate output.
- R3: While the effective high-side request and the effective low-side request are both 1, both gate outputs are 0 from the next cycle on, for as long as the overlap lasts.
- R4: After either gate output falls, neither gate output rises until it has been 0 together with the other gate for D consecutive cycles. D is the active deadtime value, with a minimum of 1.
- R5: With `dt_use` = 0, the deadtime is the parameter `DEAD_DEF` (default 20 cycles).
- R6: With `dt_use` = 1, the deadtime is taken from `dt_cfg`. This value is captured only in cycles in which no deadtime count is running. A change made during a count applies to the next count.
- R7: With `ls_invert` = 0, the effective low-side request equals the filtered `ls_req`. With `ls_invert` = 1, it is the inverse, so a high `ls_req` keeps `ls_gate` off. In inverting mode the low-side filter resets to the high (off) level.
- R8: When the other gate is off and no deadtime is pending, a request level that holds steady turns its gate on `FILT_CYC`+1 clock edges after it is first sampled. Otherwise each gate follows its own request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hs_req | input | 1 | High-side switch request, active high |
| ls_req | input | 1 | Low-side switch request; polarity set by `ls_invert` |
| ls_invert | input | 1 | 0: low-side request active high; 1: active low |
| dt_use | input | 1 | 0: default deadtime; 1: deadtime from `dt_cfg` |
| dt_cfg | input | DT_W | Deadtime in clock cycles |
| hs_gate | output | 1 | High-side gate enable |
| ls_gate | output | 1 | Low-side gate enable |

## Verification
The key coincidence comes when complementary requests swap on the same clock edge. Both filters then release in the same cycle, so one gate's turn-off and the other gate's eligibility to turn on land together. The deadtime logic must block the turn-on even though the counter has not been loaded yet. The bench provokes this by flipping both request pins on one edge. It counts the cycles in which both gates are off before the new gate rises, and compares that count with the configured deadtime, including a change of `dt_cfg` in the middle of a running count. A cycle-accurate behavioural model checks both outputs on every clock.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Gate enable pair carried through the datapath
    typedef struct packed {
        logic hs;
        logic ls;
    } gate_pair_t;

    // Cross-conduction arbitration: a side is wanted only when the other is not
    function automatic gate_pair_t arbitrate(input logic h, input logic l);
        gate_pair_t r;
        r.hs = h & ~l;
        r.ls = l & ~h;
        return r;
    endfunction

endpackage

// File: rtl/hb_pulse_filter.sv
module hb_pulse_filter #(
    parameter int FILT_CYC = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic rst_val,
    input  logic din,
    output logic dout
);
    localparam int CW = (FILT_CYC < 2) ? 1 : $clog2(FILT_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_CYC - 1);

    logic [CW-1:0] run;

    // Output follows the input only after FILT_CYC consecutive differing samples
    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= rst_val;
            run  <= '0;
        end else if (din != dout) begin
            if (run == LAST) begin
                dout <= din;
                run  <= '0;
            end else begin
                run <= run + 1'b1;
            end
        end else begin
            run <= '0;
        end
    end

endmodule

// File: rtl/hb_dead_ctrl.sv
module hb_dead_ctrl
    import hb_pkg::*;
#(
    parameter int DT_W     = 8,
    parameter int DEAD_DEF = 20
) (
    input  logic            clk,
    input  logic            rst,
    input  gate_pair_t      want,
    input  logic            dt_use,
    input  logic [DT_W-1:0] dt_cfg,
    output gate_pair_t      gate,
    output logic [DT_W-1:0] dead_cnt,
    output logic [DT_W-1:0] dt_hold
);
    localparam logic [DT_W-1:0] DEF_DT = DT_W'(DEAD_DEF);

    gate_pair_t      nxt;
    logic            idle;
    logic            off_evt;
    logic [DT_W-1:0] cnt_nxt;

    assign idle = (dead_cnt == '0);

    always_comb begin
        // A gate stays on while wanted; it may turn on only when the
        // opposite gate is off and no deadtime is pending
        nxt.hs  = want.hs & (gate.hs | (~gate.ls & idle));
        nxt.ls  = want.ls & (gate.ls | (~gate.hs & idle));
        off_evt = (gate.hs & ~nxt.hs) | (gate.ls & ~nxt.ls);
        if (off_evt)
            cnt_nxt = (dt_hold == '0) ? '0 : dt_hold - 1'b1;
        else if (!idle)
            cnt_nxt = dead_cnt - 1'b1;
        else
            cnt_nxt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            gate     <= '0;
            dead_cnt <= '0;
            dt_hold  <= DEF_DT;
        end else begin
            gate     <= nxt;
            dead_cnt <= cnt_nxt;
            if (idle)
                dt_hold <= dt_use ? dt_cfg : DEF_DT;
        end
    end

endmodule

// File: rtl/hb_interlock.sv
module hb_interlock
    import hb_pkg::*;
#(
    parameter int FILT_CYC = 7,
    parameter int DEAD_DEF = 20,
    parameter int DT_W     = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hs_req,
    input  logic            ls_req,
    input  logic            ls_invert,
    input  logic            dt_use,
    input  logic [DT_W-1:0] dt_cfg,
    output logic            hs_gate,
    output logic            ls_gate
);
    logic [1:0]      raw;
    logic [1:0]      rstv;
    logic [1:0]      filt;
    logic            eff_hs;
    logic            eff_ls;
    gate_pair_t      want;
    gate_pair_t      gate;
    logic [DT_W-1:0] dead_cnt;
    logic [DT_W-1:0] dt_hold;

    // Lane 0 is high side, lane 1 low side; low side resets to its off level
    assign raw  = {ls_req, hs_req};
    assign rstv = {ls_invert, 1'b0};

    for (genvar g = 0; g < 2; g++) begin : g_filt
        hb_pulse_filter #(.FILT_CYC(FILT_CYC)) u_filt (
            .clk    (clk),
            .rst    (rst),
            .rst_val(rstv[g]),
            .din    (raw[g]),
            .dout   (filt[g])
        );
    end

    assign eff_hs = filt[0];
    assign eff_ls = filt[1] ^ ls_invert;
    assign want   = arbitrate(eff_hs, eff_ls);

    hb_dead_ctrl #(.DT_W(DT_W), .DEAD_DEF(DEAD_DEF)) u_dead (
        .clk     (clk),
        .rst     (rst),
        .want    (want),
        .dt_use  (dt_use),
        .dt_cfg  (dt_cfg),
        .gate    (gate),
        .dead_cnt(dead_cnt),
        .dt_hold (dt_hold)
    );

    assign hs_gate = gate.hs;
    assign ls_gate = gate.ls;

endmodule

// File: rtl/hb_interlock_chk.sv
module hb_interlock_chk #(
    parameter int DT_W = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            hs_req,
    input logic            hs_gate,
    input logic            ls_gate,
    input logic            eff_hs,
    input logic            eff_ls,
    input logic            filt_hs,
    input logic [DT_W-1:0] dead_cnt,
    input logic [DT_W-1:0] dt_hold
);
    // R1
    p_reset_off_r1: assert property (@(posedge clk) $fell(rst) |-> (!hs_gate && !ls_gate));

    // R2: a filtered level can only take a value the pin already showed
    p_filter_src_r2: assert property (@(posedge clk) disable iff (rst)
        (filt_hs != $past(filt_hs)) |-> ($past(hs_req) == filt_hs));

    // R3
    p_overlap_off_r3: assert property (@(posedge clk) disable iff (rst)
        (eff_hs && eff_ls) |=> (!hs_gate && !ls_gate));

    // R4
    p_no_cross_r4: assert property (@(posedge clk) disable iff (rst)
        !(hs_gate && ls_gate));

    // R4
    p_dead_block_r4: assert property (@(posedge clk) disable iff (rst)
        (dead_cnt != '0) |=> (!$rose(hs_gate) && !$rose(ls_gate)));

    // R6
    p_cfg_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (dead_cnt != '0) |=> $stable(dt_hold));

    // R7
    p_ls_source_r7: assert property (@(posedge clk) disable iff (rst)
        ls_gate |-> $past(eff_ls));

endmodule

bind hb_interlock hb_interlock_chk #(.DT_W(DT_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .hs_req  (hs_req),
    .hs_gate (hs_gate),
    .ls_gate (ls_gate),
    .eff_hs  (eff_hs),
    .eff_ls  (eff_ls),
    .filt_hs (filt[0]),
    .dead_cnt(dead_cnt),
    .dt_hold (dt_hold)
);

// File: tb/test_hb_interlock.sv
module test_hb_interlock;
    localparam int FILT = 7;
    localparam int DDEF = 20;
    localparam int DW   = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hs_req = 1'b0, ls_req = 1'b0, ls_invert = 1'b0, dt_use = 1'b0;
    logic [DW-1:0] dt_cfg = '0;
    logic hs_gate, ls_gate;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    hb_interlock #(.FILT_CYC(FILT), .DEAD_DEF(DDEF), .DT_W(DW)) i_hb_interlock (
        .clk(clk), .rst(rst), .hs_req(hs_req), .ls_req(ls_req),
        .ls_invert(ls_invert), .dt_use(dt_use), .dt_cfg(dt_cfg),
        .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    // Behavioural reference model
    bit m_fh, m_fl, m_h, m_l;
    int m_rh, m_rl, m_cnt, m_dt;

    always @(posedge clk) begin
        bit eh, el, wh, wl, nh, nl;
        if (rst) begin
            m_fh = 0; m_fl = ls_invert; m_rh = 0; m_rl = 0;
            m_h = 0; m_l = 0; m_cnt = 0; m_dt = DDEF;
        end else begin
            eh = m_fh; el = m_fl ^ ls_invert;
            wh = eh && !el; wl = el && !eh;
            nh = wh && (m_h || (!m_l && m_cnt == 0));
            nl = wl && (m_l || (!m_h && m_cnt == 0));
            if (m_cnt == 0) begin
                if ((m_h && !nh) || (m_l && !nl)) m_cnt = (m_dt == 0) ? 0 : m_dt - 1;
                m_dt = dt_use ? int'(dt_cfg) : DDEF;
            end else begin
                m_cnt = m_cnt - 1;
            end
            m_h = nh; m_l = nl;
            if (hs_req != m_fh) begin
                m_rh++;
                if (m_rh == FILT) begin m_fh = hs_req; m_rh = 0; end
            end else m_rh = 0;
            if (ls_req != m_fl) begin
                m_rl++;
                if (m_rl == FILT) begin m_fl = ls_req; m_rl = 0; end
            end else m_rl = 0;
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (hs_gate !== m_h || ls_gate !== m_l) begin
                fails++;
                $display("FAIL %s model: hs/ls=%b%b expected %b%b at %0t",
                         cur_req, hs_gate, ls_gate, m_h, m_l, $time);
            end
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Swap the active side; count cycles with both gates off before the new side rises
    task automatic swap(input bit to_low, input int new_cfg, output int gap);
        bit changed = 0;
        hs_req = !to_low;
        ls_req = to_low ^ ls_invert;
        gap = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (!hs_gate && !ls_gate) begin
                gap++;
                if (new_cfg >= 0 && !changed) begin
                    dt_cfg = DW'(new_cfg);
                    changed = 1;
                end
            end
            if (to_low ? ls_gate : hs_gate) break;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int gap;
        // R1: reset state, including a request held during reset
        hs_req = 1;
        tick(3);
        chk("R1", {hs_gate, ls_gate}, 0);
        rst = 0;
        tick(1);
        chk("R1", {hs_gate, ls_gate}, 0);
        hs_req = 0;
        tick(12);

        // R2: 6-cycle pulse ignored
        cur_req = "R2";
        hs_req = 1; tick(FILT - 1); hs_req = 0;
        tick(12);
        chk("R2", hs_gate, 0);

        // R8: steady level propagates after FILT_CYC+1 edges
        cur_req = "R8";
        hs_req = 1;
        tick(FILT);
        chk("R8", hs_gate, 0);
        tick(1);
        chk("R8", hs_gate, 1);

        // R4/R5: default deadtime both directions
        cur_req = "R5";
        swap(1, -1, gap);
        chk("R5", gap, DDEF);
        chk("R4", {hs_gate, ls_gate}, 1);
        tick(3);
        swap(0, -1, gap);
        chk("R5", gap, DDEF);

        // R3: overlap forces both off
        cur_req = "R3";
        ls_req = 1;
        tick(FILT + 1);
        chk("R3", {hs_gate, ls_gate}, 0);
        tick(30);
        chk("R3", {hs_gate, ls_gate}, 0);
        ls_req = 0;
        tick(FILT + 4);
        chk("R3", hs_gate, 1);

        // R6: configured deadtime, change during count deferred
        cur_req = "R6";
        dt_use = 1; dt_cfg = 5;
        tick(3);
        swap(1, 30, gap);
        chk("R6", gap, 5);
        tick(3);
        swap(0, -1, gap);
        chk("R6", gap, 30);

        // R4: zero deadtime still leaves one off cycle
        cur_req = "R4";
        dt_cfg = 0;
        tick(3);
        swap(1, -1, gap);
        chk("R4", gap, 1);

        // R7: inverting mode
        cur_req = "R7";
        dt_use = 0;
        hs_req = 0; ls_req = 1; ls_invert = 1;
        tick(2);
        chk("R7", ls_gate, 0);
        tick(20);
        chk("R7", ls_gate, 0);
        ls_req = 0;
        tick(FILT + 3);
        chk("R7", ls_gate, 1);
        ls_req = 1;
        rst = 1; tick(2); rst = 0;
        tick(25);
        chk("R7", {hs_gate, ls_gate}, 0);
        ls_invert = 0; ls_req = 1;
        tick(FILT + 3);
        chk("R7", ls_gate, 1);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule